// File: doc/BRIEF.md
# Scoreboard Hazard Matrix

This block is the hazard tracker of an out-of-order issue core that runs instructions on a small pool of functional units. The issue stage presents one instruction at a time with a unit kind, a destination register and two source registers. The block binds the instruction to the lowest-numbered free unit of that kind and records its hazards in two unit-by-unit matrices. One matrix holds read-after-write waits. The other holds write-after-read holds.

Each unit gets two separate permissions. The operand-fetch permission opens when none of the unit's sources is still owed by an earlier writer. The result-write permission is not raised just because a result is ready. It is routed through the write-after-read matrix, so any earlier unit that still has to read the destination register can veto the write, and the finished result then waits inside its unit. A write that completes frees the unit and clears its row and column in both matrices in the same cycle. Ordering and hazard safety therefore come only from this gating, with no reorder buffer and no associative search.

Top module: `sbdm_core`

## Requirements
- R1: While reset is held and in the first cycle after it, no unit is busy: `go_read` and `go_write` are all zero and `issue_accept` is low whenever `issue_valid` is low.
- R2: Unit f has kind f / UNITS_PER_KIND, so units 0 and 1 are kind 0 and units 2 and 3 are kind 1 with the default parameters. An accepted issue binds the lowest-numbered free unit of the requested kind and reports its index on `issue_unit`. `issue_accept` is low when every unit of that kind is busy.
- R3: `issue_accept` is low while any busy unit has the requested destination register, including a unit whose write completes in that same cycle.
- R4: `go_read` for a unit is high exactly when the unit is busy, has not yet read, and no earlier instruction whose destination matches one of its sources has finished writing before that cycle. The operands read then equal the values that program order gives.
- R5: A writer whose write completes in the same cycle as a new issue creates no read-after-write wait for that new instruction, because the register file writes through.
- R6: `go_write` for a unit is high exactly when the unit has read its operands, `unit_result_ready` is high, and no earlier-issued instruction that has not yet read has a source equal to this unit's destination. Otherwise the result is held.
- R7: `unit_read_done` given in a `go_read` cycle ends the unit's read phase. From the next cycle it lifts the write-after-read holds that it caused and `go_read` stays low.
- R8: A cycle with `go_write` high completes the write. The unit is free for issue from the next cycle and takes part in no hazard from then on.
- R9: After a program has fully drained, the register contents equal those of strict sequential execution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | An instruction is offered for issue |
| issue_kind | input | KW | Requested unit kind |
| issue_dst | input | RW | Destination register number |
| issue_src1 | input | RW | First source register number |
| issue_src2 | input | RW | Second source register number |
| issue_accept | output | 1 | The offered instruction is taken this cycle |
| issue_unit | output | FW | Index of the unit bound on accept |
| unit_read_done | input | NF | Unit read its operands (only in a `go_read` cycle) |
| unit_result_ready | input | NF | Unit holds a finished result |
| go_read | output | NF | Per-unit permission to fetch operands |
| go_write | output | NF | Per-unit permission to write the result; the write completes in this cycle |

## Verification
The assertions assume that a unit raises `unit_read_done` only in a cycle where its `go_read` is high, and that once it raises `unit_result_ready` it holds the signal until `go_write` is granted. The bench models each unit so that it obeys both rules. A unit acknowledges a read in the same cycle it sees `go_read`, and it keeps its ready flag up until the write is granted. The instruction table uses register numbers inside the register count and kinds inside the kind count, and it mixes fast and slow units so that waits of every type, including a write veto, actually arise.

// File: rtl/sbdm_pkg.sv
package sbdm_pkg;
    localparam int SB_KINDS    = 2;
    localparam int SB_PER_KIND = 2;
    localparam int SB_REGS     = 16;

    function automatic int sb_idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/sbdm_alloc.sv
module sbdm_alloc #(
    parameter int NK = 2,
    parameter int PK = 2,
    localparam int NF = NK * PK,
    localparam int KW = sbdm_pkg::sb_idx_w(NK),
    localparam int FW = sbdm_pkg::sb_idx_w(NF)
) (
    input  logic [NF-1:0] busy,
    input  logic [KW-1:0] kind,
    output logic          found,
    output logic [FW-1:0] unit
);
    always_comb begin
        int base;
        base  = int'(kind) * PK;
        found = 1'b0;
        unit  = '0;
        for (int i = PK - 1; i >= 0; i--) begin
            if ((base + i) < NF) begin
                if (!busy[base + i]) begin
                    found = 1'b1;
                    unit  = FW'(base + i);
                end
            end
        end
    end
endmodule

// File: rtl/sbdm_match.sv
module sbdm_match #(
    parameter int NF = 4,
    parameter int RW = 4
) (
    input  logic [NF-1:0]         busy,
    input  logic [NF-1:0]         rd_pend,
    input  logic [NF-1:0]         wr_now,
    input  logic [NF-1:0]         rd_now,
    input  logic [NF-1:0][RW-1:0] dst,
    input  logic [NF-1:0][RW-1:0] src1,
    input  logic [NF-1:0][RW-1:0] src2,
    input  logic [RW-1:0]         n_dst,
    input  logic [RW-1:0]         n_src1,
    input  logic [RW-1:0]         n_src2,
    output logic [NF-1:0]         raw_row,
    output logic [NF-1:0]         war_row,
    output logic                  waw_hit
);
    logic [NF-1:0] waw_v;

    for (genvar g = 0; g < NF; g++) begin : g_col
        assign raw_row[g] = busy[g] & ~wr_now[g] &
                            ((dst[g] == n_src1) | (dst[g] == n_src2));
        assign war_row[g] = busy[g] & rd_pend[g] & ~rd_now[g] &
                            ((src1[g] == n_dst) | (src2[g] == n_dst));
        assign waw_v[g]   = busy[g] & (dst[g] == n_dst);
    end

    assign waw_hit = |waw_v;
endmodule

// File: rtl/sbdm_grant.sv
module sbdm_grant #(
    parameter int NF = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NF-1:0]         busy,
    input  logic [NF-1:0]         rd_pend,
    input  logic [NF-1:0][NF-1:0] raw,
    input  logic [NF-1:0][NF-1:0] war,
    input  logic [NF-1:0]         result_ready,
    input  logic [NF-1:0]         read_done,
    output logic [NF-1:0]         go_read,
    output logic [NF-1:0]         go_write
);
    for (genvar f = 0; f < NF; f++) begin : g_unit
        assign go_read[f]  = busy[f] & rd_pend[f] & ~(|raw[f]);
        assign go_write[f] = busy[f] & ~rd_pend[f] & result_ready[f] & ~(|war[f]);

        assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
            go_write[f] |=> !busy[f]);
        assert_read_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
            read_done[f] |=> !go_read[f]);
        assert_read_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
            read_done[f] |-> go_read[f]);
        assert_result_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (result_ready[f] && !go_write[f]) |=> result_ready[f]);
    end
endmodule

// File: rtl/sbdm_core.sv
module sbdm_core #(
    parameter int NUM_KINDS      = sbdm_pkg::SB_KINDS,
    parameter int UNITS_PER_KIND = sbdm_pkg::SB_PER_KIND,
    parameter int NUM_REGS       = sbdm_pkg::SB_REGS,
    localparam int NF = NUM_KINDS * UNITS_PER_KIND,
    localparam int RW = sbdm_pkg::sb_idx_w(NUM_REGS),
    localparam int KW = sbdm_pkg::sb_idx_w(NUM_KINDS),
    localparam int FW = sbdm_pkg::sb_idx_w(NF)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue_valid,
    input  logic [KW-1:0] issue_kind,
    input  logic [RW-1:0] issue_dst,
    input  logic [RW-1:0] issue_src1,
    input  logic [RW-1:0] issue_src2,
    output logic          issue_accept,
    output logic [FW-1:0] issue_unit,
    input  logic [NF-1:0] unit_read_done,
    input  logic [NF-1:0] unit_result_ready,
    output logic [NF-1:0] go_read,
    output logic [NF-1:0] go_write
);
    typedef struct packed {
        logic [NF-1:0]         busy;
        logic [NF-1:0]         rd_pend;
        logic [NF-1:0][RW-1:0] dst;
        logic [NF-1:0][RW-1:0] src1;
        logic [NF-1:0][RW-1:0] src2;
        logic [NF-1:0][NF-1:0] raw;
        logic [NF-1:0][NF-1:0] war;
    } sb_state_t;

    sb_state_t st_q, st_d;

    logic          free_found;
    logic [FW-1:0] free_unit;
    logic [NF-1:0] raw_row, war_row;
    logic          waw_hit;
    logic [NF-1:0] rd_now;

    assign rd_now = unit_read_done & go_read;

    sbdm_alloc #(.NK(NUM_KINDS), .PK(UNITS_PER_KIND)) u_alloc (
        .busy  (st_q.busy),
        .kind  (issue_kind),
        .found (free_found),
        .unit  (free_unit)
    );

    sbdm_match #(.NF(NF), .RW(RW)) u_match (
        .busy    (st_q.busy),
        .rd_pend (st_q.rd_pend),
        .wr_now  (go_write),
        .rd_now  (rd_now),
        .dst     (st_q.dst),
        .src1    (st_q.src1),
        .src2    (st_q.src2),
        .n_dst   (issue_dst),
        .n_src1  (issue_src1),
        .n_src2  (issue_src2),
        .raw_row (raw_row),
        .war_row (war_row),
        .waw_hit (waw_hit)
    );

    sbdm_grant #(.NF(NF)) u_grant (
        .clk          (clk),
        .rst_n        (rst_n),
        .busy         (st_q.busy),
        .rd_pend      (st_q.rd_pend),
        .raw          (st_q.raw),
        .war          (st_q.war),
        .result_ready (unit_result_ready),
        .read_done    (unit_read_done),
        .go_read      (go_read),
        .go_write     (go_write)
    );

    assign issue_accept = issue_valid & free_found & ~waw_hit;
    assign issue_unit   = free_unit;

    always_comb begin
        st_d = st_q;
        for (int f = 0; f < NF; f++) begin
            if (rd_now[f]) begin
                st_d.rd_pend[f] = 1'b0;
                for (int g = 0; g < NF; g++) st_d.war[g][f] = 1'b0;
            end
            if (go_write[f]) begin
                st_d.busy[f] = 1'b0;
                st_d.raw[f]  = '0;
                st_d.war[f]  = '0;
                for (int g = 0; g < NF; g++) begin
                    st_d.raw[g][f] = 1'b0;
                    st_d.war[g][f] = 1'b0;
                end
            end
        end
        if (issue_accept) begin
            st_d.busy[issue_unit]    = 1'b1;
            st_d.rd_pend[issue_unit] = 1'b1;
            st_d.dst[issue_unit]     = issue_dst;
            st_d.src1[issue_unit]    = issue_src1;
            st_d.src2[issue_unit]    = issue_src2;
            st_d.raw[issue_unit]     = raw_row;
            st_d.war[issue_unit]     = war_row;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_alloc_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
        issue_accept |-> !st_q.busy[issue_unit]);
    assert_issue_binds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        issue_accept |=> st_q.busy[$past(issue_unit)]);
    assert_pend_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.rd_pend & ~st_q.busy) == '0);

    for (genvar a = 0; a < NF; a++) begin : g_pa
        for (genvar b = a + 1; b < NF; b++) begin : g_pb
            assert_one_writer_R3: assert property (@(posedge clk) disable iff (!rst_n)
                !(st_q.busy[a] && st_q.busy[b] && (st_q.dst[a] == st_q.dst[b])));
        end
    end
endmodule

// File: tb/sbdm_core_test.sv
module sbdm_core_test;
    localparam int NF = 4;
    localparam int PK = 2;
    localparam int NR = 16;
    localparam int NI = 20;

    // {kind, dst, src1, src2}
    localparam logic [12:0] PROG [NI] = '{
        {1'b1, 4'd1,  4'd2,  4'd3},
        {1'b0, 4'd4,  4'd1,  4'd1},
        {1'b0, 4'd2,  4'd5,  4'd6},
        {1'b1, 4'd5,  4'd4,  4'd2},
        {1'b0, 4'd6,  4'd7,  4'd7},
        {1'b0, 4'd7,  4'd6,  4'd1},
        {1'b1, 4'd1,  4'd4,  4'd5},
        {1'b1, 4'd8,  4'd1,  4'd7},
        {1'b0, 4'd3,  4'd8,  4'd2},
        {1'b0, 4'd7,  4'd3,  4'd3},
        {1'b1, 4'd3,  4'd7,  4'd1},
        {1'b0, 4'd10, 4'd3,  4'd8},
        {1'b1, 4'd2,  4'd10, 4'd10},
        {1'b0, 4'd11, 4'd2,  4'd5},
        {1'b0, 4'd5,  4'd11, 4'd12},
        {1'b1, 4'd12, 4'd0,  4'd5},
        {1'b0, 4'd0,  4'd12, 4'd11},
        {1'b1, 4'd13, 4'd0,  4'd0},
        {1'b0, 4'd12, 4'd13, 4'd3},
        {1'b0, 4'd14, 4'd12, 4'd0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          issue_valid = 1'b0;
    logic [0:0]    issue_kind = '0;
    logic [3:0]    issue_dst = '0, issue_src1 = '0, issue_src2 = '0;
    logic          issue_accept;
    logic [1:0]    issue_unit;
    logic [NF-1:0] unit_read_done = '0;
    logic [NF-1:0] unit_result_ready = '0;
    logic [NF-1:0] go_read, go_write;

    always #5 clk = ~clk;

    sbdm_core uut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_kind(issue_kind),
        .issue_dst(issue_dst), .issue_src1(issue_src1), .issue_src2(issue_src2),
        .issue_accept(issue_accept), .issue_unit(issue_unit),
        .unit_read_done(unit_read_done), .unit_result_ready(unit_result_ready),
        .go_read(go_read), .go_write(go_write)
    );

    int checks = 0, failures = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int f_kind(int i); return int'(PROG[i][12]); endfunction
    function automatic int f_dst(int i);  return int'(PROG[i][11:8]); endfunction
    function automatic int f_s1(int i);   return int'(PROG[i][7:4]); endfunction
    function automatic int f_s2(int i);   return int'(PROG[i][3:0]); endfunction

    logic [15:0] regs [NR];
    logic [15:0] seq_regs [NR];
    logic [15:0] exp_a [NI], exp_b [NI];
    bit wr_done [NI], rd_done [NI];
    bit u_act [NF], u_read [NF];
    int u_seq [NF], u_rdy [NF];
    logic [15:0] u_res [NF];

    initial begin
        int pc, cyc, nwr;
        for (int r = 0; r < NR; r++) begin
            regs[r] = 16'(r * 3 + 1);
            seq_regs[r] = regs[r];
        end
        for (int i = 0; i < NI; i++) begin
            exp_a[i] = seq_regs[f_s1(i)];
            exp_b[i] = seq_regs[f_s2(i)];
            seq_regs[f_dst(i)] = exp_a[i] + exp_b[i] + 16'(i);
            wr_done[i] = 0; rd_done[i] = 0;
        end
        for (int f = 0; f < NF; f++) begin u_act[f] = 0; u_read[f] = 0; end

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(go_read == '0 && go_write == '0 && !issue_accept, "R1 idle in reset", int'(go_read), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(go_read == '0 && go_write == '0 && !issue_accept, "R1 idle after reset", int'(go_write), 0);

        pc = 0; cyc = 0; nwr = 0;
        while (nwr < NI) begin
            @(negedge clk);
            unit_read_done = '0;
            for (int f = 0; f < NF; f++)
                unit_result_ready[f] = u_act[f] && u_read[f] && (cyc >= u_rdy[f]);
            if (pc < NI) begin
                issue_valid = 1'b1;
                issue_kind  = 1'(f_kind(pc));
                issue_dst   = 4'(f_dst(pc));
                issue_src1  = 4'(f_s1(pc));
                issue_src2  = 4'(f_s2(pc));
            end else begin
                issue_valid = 1'b0;
            end
            #1;
            // expectations from the bench's own bookkeeping
            for (int f = 0; f < NF; f++) begin
                bit er, ew;
                er = 0; ew = 0;
                if (u_act[f] && !u_read[f]) begin
                    er = 1;
                    for (int j = 0; j < u_seq[f]; j++)
                        if (!wr_done[j] && (f_dst(j) == f_s1(u_seq[f]) || f_dst(j) == f_s2(u_seq[f])))
                            er = 0;
                end
                if (u_act[f] && u_read[f] && unit_result_ready[f]) begin
                    ew = 1;
                    for (int j = 0; j < u_seq[f]; j++)
                        if (!rd_done[j] && (f_s1(j) == f_dst(u_seq[f]) || f_s2(j) == f_dst(u_seq[f])))
                            ew = 0;
                end
                // R4 and R5: read permission exactly when sources are settled
                chk(go_read[f] == er, $sformatf("R4 go_read unit %0d", f), int'(go_read[f]), int'(er));
                // R6: write permission vetoed by pending earlier readers
                chk(go_write[f] == ew, $sformatf("R6 go_write unit %0d", f), int'(go_write[f]), int'(ew));
            end
            if (pc < NI) begin
                bit ea; int eu;
                ea = 0; eu = 0;
                for (int u = f_kind(pc) * PK + PK - 1; u >= f_kind(pc) * PK; u--)
                    if (!u_act[u]) begin ea = 1; eu = u; end
                for (int j = 0; j < pc; j++)
                    if (!wr_done[j] && f_dst(j) == f_dst(pc)) ea = 0;  // R3 pending writer
                chk(issue_accept == ea, "R2/R3 issue_accept", int'(issue_accept), int'(ea));
                if (ea) chk(int'(issue_unit) == eu, "R2 issue_unit", int'(issue_unit), eu);
            end
            // apply writes, then reads, then issue
            for (int f = 0; f < NF; f++)
                if (go_write[f] && u_act[f]) begin
                    regs[f_dst(u_seq[f])] = u_res[f];
                    wr_done[u_seq[f]] = 1;
                    u_act[f] = 0;
                    nwr++;
                end
            for (int f = 0; f < NF; f++)
                if (go_read[f] && u_act[f] && !u_read[f]) begin
                    int s;
                    s = u_seq[f];
                    chk(regs[f_s1(s)] == exp_a[s], "R4 operand a", int'(regs[f_s1(s)]), int'(exp_a[s]));
                    chk(regs[f_s2(s)] == exp_b[s], "R4 operand b", int'(regs[f_s2(s)]), int'(exp_b[s]));
                    u_res[f] = regs[f_s1(s)] + regs[f_s2(s)] + 16'(s);
                    unit_read_done[f] = 1'b1;  // R7 acknowledge in the grant cycle
                    rd_done[s] = 1;
                    u_read[f] = 1;
                    u_rdy[f] = cyc + ((f_kind(s) == 1) ? 4 : 1);
                end
            if (pc < NI && issue_accept) begin
                u_act[issue_unit] = 1;
                u_read[issue_unit] = 0;
                u_seq[issue_unit] = pc;
                pc++;
            end
            cyc++;
            if (cyc > 2000) begin
                chk(0, "watchdog", cyc, 2000);
                break;
            end
        end

        @(negedge clk);
        unit_read_done = '0;
        unit_result_ready = '0;
        issue_valid = 1'b0;
        #1;
        chk(go_read == '0 && go_write == '0, "R8 drained units idle", int'(go_read | go_write), 0);
        for (int r = 0; r < NR; r++)
            chk(regs[r] == seq_regs[r], $sformatf("R9 reg %0d", r), int'(regs[r]), int'(seq_regs[r]));

        // R8: every unit of kind 1 is free again and the lowest is picked
        issue_valid = 1'b1; issue_kind = 1'b1;
        issue_dst = 4'd15; issue_src1 = 4'd0; issue_src2 = 4'd0;
        #1;
        chk(issue_accept && issue_unit == 2'd2, "R8 freed unit reissued", int'(issue_unit), 2);
        @(negedge clk);
        // R3: same destination now has a pending writer
        issue_kind = 1'b0;
        #1;
        chk(!issue_accept, "R3 pending writer stalls", int'(issue_accept), 0);
        issue_valid = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule